// File: doc/BRIEF.md
# Chained receive DMA controller

This block moves words from a receiving peripheral into memory without processor help. Software loads a start address (index), a signed step (modifier) and a word count, then sets the control bits. Each word the peripheral offers is written at the current index, after which the index moves by the step and the count drops by one.

When chaining is on, the block follows a linked list of four-word transfer descriptors held in the same memory. A descriptor sits at four consecutive addresses, from lowest to highest: link, count, step, index. A link always holds the address of the highest word of the next descriptor, so the block reads a descriptor from the top down. Writing a nonzero link value starts the chain. The first transfer uses the directly written parameters. Each later transfer uses the descriptor the previous link pointed to. A zero link ends the chain and raises the done flag.

While a descriptor is being read, the ready signal to the peripheral is held low. Memory reads return data one cycle after the request.

Top module: `rxdma_chain`

## Requirements
- R1: While reset is held and in the first cycle after it, rx_ready, mem_we, mem_re and done are all low.
- R2: Register select 0 is control, with bit 0 as enable, bit 1 as receive direction and bit 4 as chaining. Select 1 is index, 2 is step, 3 is count and 4 is link. Link values are truncated to AW bits (19 by default). When the block is idle and the control register has enable, receive and chaining set, a write to link whose truncated value is nonzero starts a transfer. If the truncated value is zero, nothing starts.
- R3: Each accepted word (rx_valid and rx_ready both high) is written in the same cycle to mem_waddr equal to the current index. The index then becomes index plus step modulo 2^AW, and the count decreases by one.
- R4: rx_ready is high only while a transfer runs with a nonzero count. After count words, it drops.
- R5: When a chained transfer ends and the link is nonzero, the block issues four reads on consecutive cycles at link, link-1, link-2 and link-3. The first read comes in the cycle after the last accepted word. rx_ready is low from that cycle and rises again 5 cycles after the first read.
- R6: The word read at link becomes the index, link-1 becomes the step, link-2 becomes the count, and link-3 becomes the next link (truncated to AW bits).
- R7: When a transfer ends with a zero link, or with chaining off, done goes high in the cycle after the last accepted word, and no descriptor is read. Writing control with bit 0 clear returns the block to idle and clears done by the next cycle.
- R8: The first transfer after a start uses the index, step and count written directly, before any descriptor is read.
- R9: With chaining off, a control write that sets enable and receive starts a transfer of the direct parameters. At its end the block stops and raises done, whatever the link holds.
- R10: Writes to index, step, count and link are ignored while a transfer or a descriptor read is in progress.
- R11: Nothing starts while the receive bit is clear: rx_ready stays low even after a nonzero link write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | DW | Register write data |
| rx_valid | input | 1 | Peripheral has a word |
| rx_data | input | DW | Received word |
| rx_ready | output | 1 | Block accepts a word this cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_waddr | output | AW | Memory write address |
| mem_wdata | output | DW | Memory write data |
| mem_re | output | 1 | Memory read request |
| mem_raddr | output | AW | Memory read address |
| mem_rdata | input | DW | Read data, valid one cycle after mem_re |
| done | output | 1 | Final transfer of the chain completed |

## Verification
The memory write is combinational from the handshake, so the bench drives rx_valid at a falling edge and samples mem_we, mem_waddr and mem_wdata 1 ns later, in the same cycle. A start, the end of a transfer and a control write each take effect at the next rising edge. The bench therefore reads rx_ready and done at the following falling edge. For each word, the stimulus table holds the number of low-ready cycles the bench must wait, which is 5 after each descriptor read. A monitor logs each read address at the rising edge it is issued on, and checks that reads come in order and on consecutive cycles.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FETCH,
    ST_DONE
  } dma_state_e;

  localparam logic [2:0] SEL_CTRL  = 3'd0;
  localparam logic [2:0] SEL_INDEX = 3'd1;
  localparam logic [2:0] SEL_STEP  = 3'd2;
  localparam logic [2:0] SEL_COUNT = 3'd3;
  localparam logic [2:0] SEL_LINK  = 3'd4;

  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_RX_BIT    = 1;
  localparam int CTRL_CHAIN_BIT = 4;

  // descriptor words in fetch order (highest address first)
  typedef enum logic [1:0] {
    FLD_INDEX,
    FLD_STEP,
    FLD_COUNT,
    FLD_LINK
  } tcb_field_e;

endpackage

// File: rtl/rxdma_params.sv
module rxdma_params
  import rxdma_pkg::*;
#(
  parameter int AW = 19,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [2:0]    host_sel,
  input  logic [DW-1:0] host_data,
  input  logic          host_ok,
  input  logic          adv,
  input  logic          ld_we,
  input  tcb_field_e    ld_field,
  input  logic [DW-1:0] ld_data,
  output logic [AW-1:0] idx,
  output logic [AW-1:0] step,
  output logic [CW-1:0] cnt,
  output logic [AW-1:0] link,
  output logic          ctl_en,
  output logic          ctl_rx,
  output logic          ctl_chain
);

  function automatic logic [AW-1:0] step_index(input logic [AW-1:0] a, input logic [AW-1:0] s);
    return a + s;
  endfunction

  function automatic logic [CW-1:0] count_less_one(input logic [CW-1:0] c);
    return c - CW'(1);
  endfunction

  logic host_param;
  assign host_param = host_we && host_ok;

  logic unused_hi;
  assign unused_hi = ^{host_data[DW-1:AW], ld_data[DW-1:AW]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx       <= '0;
      step      <= '0;
      cnt       <= '0;
      link      <= '0;
      ctl_en    <= 1'b0;
      ctl_rx    <= 1'b0;
      ctl_chain <= 1'b0;
    end else begin
      if (host_we && host_sel == SEL_CTRL) begin
        ctl_en    <= host_data[CTRL_EN_BIT];
        ctl_rx    <= host_data[CTRL_RX_BIT];
        ctl_chain <= host_data[CTRL_CHAIN_BIT];
      end
      if (ld_we && ld_field == FLD_INDEX)
        idx <= ld_data[AW-1:0];
      else if (adv)
        idx <= step_index(idx, step);
      else if (host_param && host_sel == SEL_INDEX)
        idx <= host_data[AW-1:0];
      if (ld_we && ld_field == FLD_STEP)
        step <= ld_data[AW-1:0];
      else if (host_param && host_sel == SEL_STEP)
        step <= host_data[AW-1:0];
      if (ld_we && ld_field == FLD_COUNT)
        cnt <= ld_data[CW-1:0];
      else if (adv)
        cnt <= count_less_one(cnt);
      else if (host_param && host_sel == SEL_COUNT)
        cnt <= host_data[CW-1:0];
      if (ld_we && ld_field == FLD_LINK)
        link <= ld_data[AW-1:0];
      else if (host_param && host_sel == SEL_LINK)
        link <= host_data[AW-1:0];
    end
  end

  AST_NO_HOST_DURING_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    !(adv && host_param)) else $error("host write accepted during transfer"); // R10

  AST_NO_LOAD_DURING_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    !(adv && ld_we)) else $error("descriptor load during accepted word"); // R5

endmodule

// File: rtl/rxdma_tcb_fetch.sv
module rxdma_tcb_fetch
  import rxdma_pkg::*;
#(
  parameter int AW = 19,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base,
  input  logic [DW-1:0] rdata,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          ld_we,
  output tcb_field_e    ld_field,
  output logic [DW-1:0] ld_data,
  output logic          fin
);

  localparam int NWORDS = 4;
  localparam int SW     = $clog2(NWORDS + 1);

  function automatic logic [AW-1:0] tcb_word_addr(input logic [AW-1:0] top, input logic [SW-1:0] k);
    return top - AW'(k);
  endfunction

  logic          active;
  logic [SW-1:0] fstep;
  logic [AW-1:0] base_q;

  assign rd_en    = active && (fstep < SW'(NWORDS));
  assign rd_addr  = tcb_word_addr(base_q, fstep);
  assign ld_we    = active && (fstep != '0);
  assign ld_field = tcb_field_e'(fstep[1:0] - 2'd1);
  assign ld_data  = rdata;
  assign fin      = active && (fstep == SW'(NWORDS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      fstep  <= '0;
      base_q <= '0;
    end else if (start) begin
      active <= 1'b1;
      fstep  <= '0;
      base_q <= base;
    end else if (active) begin
      if (fin) active <= 1'b0;
      else     fstep  <= fstep + SW'(1);
    end
  end

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active) else $error("fetch restarted while busy"); // R5

  AST_FIN_AFTER_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> $past(rd_en)) else $error("fetch finished without final read"); // R6

endmodule

// File: rtl/rxdma_chain.sv
module rxdma_chain
  import rxdma_pkg::*;
#(
  parameter int AW = 19,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_re,
  output logic [AW-1:0] mem_raddr,
  input  logic [DW-1:0] mem_rdata,
  output logic          done
);

  dma_state_e    state, state_nx;
  logic [AW-1:0] idx, step, link;
  logic [CW-1:0] cnt;
  logic          ctl_en, ctl_rx, ctl_chain;
  logic          hs, host_ok, ld_we, fin, fetch_go;
  tcb_field_e    ld_field;
  logic [DW-1:0] ld_data;

  // named events for the checks
  logic ctl_wr, link_wr, stop_req, chain_start, plain_start, run_end;

  assign ctl_wr      = cfg_we && cfg_sel == SEL_CTRL;
  assign link_wr     = cfg_we && cfg_sel == SEL_LINK;
  assign stop_req    = ctl_wr && !cfg_wdata[CTRL_EN_BIT];
  assign chain_start = link_wr && ctl_en && ctl_rx && ctl_chain && (cfg_wdata[AW-1:0] != '0);
  assign plain_start = ctl_wr && cfg_wdata[CTRL_EN_BIT] && cfg_wdata[CTRL_RX_BIT]
                       && !cfg_wdata[CTRL_CHAIN_BIT];
  assign hs          = rx_valid && rx_ready;
  assign run_end     = (cnt == '0) || (hs && cnt == CW'(1));
  assign fetch_go    = (state == ST_RUN) && run_end && ctl_chain && (link != '0);
  assign host_ok     = (state == ST_IDLE) || (state == ST_DONE);

  assign rx_ready  = (state == ST_RUN) && (cnt != '0);
  assign mem_we    = hs;
  assign mem_waddr = idx;
  assign mem_wdata = rx_data;
  assign done      = (state == ST_DONE);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (chain_start || plain_start) state_nx = ST_RUN;
      ST_RUN:   if (run_end) state_nx = fetch_go ? ST_FETCH : ST_DONE;
      ST_FETCH: if (fin) state_nx = ST_RUN;
      ST_DONE:  state_nx = ST_DONE;
      default:  state_nx = ST_IDLE;
    endcase
    if (stop_req) state_nx = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  rxdma_params #(.AW(AW), .DW(DW), .CW(CW)) params_i (
    .clk(clk), .rst_n(rst_n),
    .host_we(cfg_we), .host_sel(cfg_sel), .host_data(cfg_wdata), .host_ok(host_ok),
    .adv(hs), .ld_we(ld_we), .ld_field(ld_field), .ld_data(ld_data),
    .idx(idx), .step(step), .cnt(cnt), .link(link),
    .ctl_en(ctl_en), .ctl_rx(ctl_rx), .ctl_chain(ctl_chain)
  );

  rxdma_tcb_fetch #(.AW(AW), .DW(DW)) fetch_i (
    .clk(clk), .rst_n(rst_n),
    .start(fetch_go && !stop_req), .base(link), .rdata(mem_rdata),
    .rd_en(mem_re), .rd_addr(mem_raddr),
    .ld_we(ld_we), .ld_field(ld_field), .ld_data(ld_data), .fin(fin)
  );

  AST_NO_READ_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && rx_ready)) else $error("ready during descriptor read"); // R5

  AST_READ_DESCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && $past(mem_re)) |-> mem_raddr == $past(mem_raddr) - AW'(1))
    else $error("descriptor reads not descending"); // R5

  AST_WRITE_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> mem_waddr == $past(mem_waddr) + $past(step))
    else $error("index did not advance by step"); // R3

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> cnt == $past(cnt) - CW'(1)) else $error("count not decremented"); // R3

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rx_ready && !mem_re && !mem_we) else $error("activity while done"); // R7

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !done) else $error("done not cleared by disable"); // R7

endmodule

// File: tb/rxdma_chain_tb.sv
module rxdma_chain_tb_top;

  localparam int AW = 19;
  localparam int DW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_sel = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic          rx_valid = 1'b0;
  logic [DW-1:0] rx_data = '0;
  logic          rx_ready, mem_we, mem_re, done;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 1'b0;

  logic [DW-1:0] tmem [64];
  int rd_addr_log [16];
  int rd_cyc_log [16];
  int rd_n = 0;

  always #10 clk = ~clk;

  rxdma_chain #(.AW(AW), .DW(DW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .mem_re(mem_re), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata), .done(done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_re) begin
      mem_rdata <= tmem[mem_raddr[5:0]];
      if (rd_n < 16) begin
        rd_addr_log[rd_n] = int'(mem_raddr);
        rd_cyc_log[rd_n]  = cyc;
      end
      rd_n = rd_n + 1;
    end
  end

  // data, expected write address, expected idle-ready cycles before the word
  localparam int unsigned VEC [7][3] = '{
    '{32'hA0, 8,  0},
    '{32'hA1, 9,  0},
    '{32'hA2, 10, 0},
    '{32'hA3, 40, 5},
    '{32'hA4, 43, 0},
    '{32'hA5, 50, 5},
    '{32'hA6, 49, 0}
  };
  localparam int EXP_RD [8] = '{23, 22, 21, 20, 33, 32, 31, 30};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] sel, input logic [DW-1:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic push(input logic [DW-1:0] d, input int exp_addr, input int exp_wait, input string req);
    int w = 0;
    while (!rx_ready && w < 40) begin
      @(negedge clk);
      w++;
    end
    check(w == exp_wait, {req, " ready wait"}, w, exp_wait);
    rx_valid = 1'b1; rx_data = d;
    #1;
    check(mem_we == 1'b1, {req, " mem_we"}, int'(mem_we), 1);
    check(int'(mem_waddr) == exp_addr, {req, " waddr"}, int'(mem_waddr), exp_addr);
    check(mem_wdata == d, {req, " wdata"}, int'(mem_wdata), int'(d));
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) tmem[i] = '0;
    tmem[20] = 33; tmem[21] = 2; tmem[22] = 3;  tmem[23] = 40;
    tmem[30] = 0;  tmem[31] = 2; tmem[32] = 32'h7FFFF; tmem[33] = 50;

    // R1: reset state
    repeat (3) @(negedge clk);
    check({rx_ready, mem_we, mem_re, done} == 4'b0, "R1 in reset", {rx_ready, mem_we, mem_re, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({rx_ready, mem_we, mem_re, done} == 4'b0, "R1 after reset", {rx_ready, mem_we, mem_re, done}, 0);

    // R2: link write truncated to zero does not start
    cfg_write(3'd0, 32'h13);
    cfg_write(3'd1, 8);
    cfg_write(3'd2, 1);
    cfg_write(3'd3, 3);
    cfg_write(3'd4, 32'h80000);
    repeat (3) @(negedge clk);
    check(!rx_ready && !mem_re, "R2 zero link no start", {rx_ready, mem_re}, 0);

    // R11: receive bit clear, nothing starts
    cfg_write(3'd0, 32'h11);
    cfg_write(3'd4, 23);
    repeat (3) @(negedge clk);
    check(!rx_ready && !mem_re, "R11 rx clear no start", {rx_ready, mem_re}, 0);

    // R2 R8 R3 R5 R6: chained run, start by masked link write
    cfg_write(3'd0, 32'h13);
    cfg_write(3'd4, 32'h80017);
    for (int i = 0; i < 7; i++)
      push(VEC[i][0], int'(VEC[i][1]), int'(VEC[i][2]), $sformatf("R3 R5 R6 R8 word%0d", i));
    // R7: done after last word with zero link
    check(done == 1'b1, "R7 done set", int'(done), 1);
    check(!rx_ready, "R4 ready low at end", int'(rx_ready), 0);
    check(rd_n == 8, "R5 read count", rd_n, 8);
    for (int i = 0; i < 8; i++) begin
      check(rd_addr_log[i] == EXP_RD[i], "R5 read address", rd_addr_log[i], EXP_RD[i]);
      if (i % 4 != 0)
        check(rd_cyc_log[i] == rd_cyc_log[i-1] + 1, "R5 consecutive reads", rd_cyc_log[i], rd_cyc_log[i-1] + 1);
    end
    repeat (3) @(negedge clk);
    check(done && rd_n == 8, "R7 no further fetch", rd_n, 8);
    cfg_write(3'd0, 32'h0);
    check(!done, "R7 done cleared", int'(done), 0);

    // R9 R10: chaining off, link ignored; writes during run ignored
    cfg_write(3'd1, 5);
    cfg_write(3'd2, 1);
    cfg_write(3'd3, 2);
    cfg_write(3'd4, 23);
    cfg_write(3'd0, 32'h03);
    push(32'hB0, 5, 0, "R9 word0");
    cfg_write(3'd1, 60);
    push(32'hB1, 6, 0, "R10 word1");
    check(done == 1'b1, "R9 done set", int'(done), 1);
    check(!rx_ready, "R4 ready low after count", int'(rx_ready), 0);
    repeat (6) @(negedge clk);
    check(rd_n == 8 && !mem_re, "R9 no descriptor read", rd_n, 8);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule